// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block expands one column access command into the ordered column addresses of a double-data-rate SDRAM burst. Two data beats move on every clock, so the block offers one pair of column addresses per cycle: the address for the even beat and the address for the odd beat. A burst of length L therefore needs L/2 pair transfers. The block also decodes and holds the two mode fields it needs: the burst length and the ordering rule. The ordering is either sequential, which wraps inside an aligned block of L columns, or interleaved, which XORs the beat number into the low address bits.

Commands enter on a valid/ready port, and address pairs leave on a valid/ready port. The command port accepts only while no burst is in flight. The address port holds each pair steady until the consumer takes it, so the consumer can stall the burst at any time. A stop request ends a read burst at once. A write burst ignores the stop request. A single-cycle `done` marks the end of each burst. Mode writes use a plain strobe. A write with a reserved length code is rejected and reported.

Top module: `ddr_burst_colseq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `out_valid`, `done` and `mode_illegal` are 0. The mode is burst length 2 in sequential order.
- R2: `mode_word[2:0]` selects the burst length: 1 gives 2, 2 gives 4 and 3 gives 8. `mode_word[3]` selects the order: 0 is sequential and 1 is interleaved. A legal word written with `mode_wr` applies to commands accepted in later cycles.
- R3: A `mode_wr` whose length code is 0, 4, 5, 6 or 7 drives `mode_illegal` high for exactly the next cycle. That write changes neither the length nor the order.
- R4: In sequential order with start column S and length L, beat i carries (S with its low log2(L) bits replaced by (S + i) mod L).
- R5: In interleaved order, beat i carries S with its low log2(L) bits XORed with i.
- R6: Pair k carries beat 2k on `out_col_even` and beat 2k+1 on `out_col_odd`, together with the command's bank. A burst that is not stopped transfers exactly L/2 pairs.
- R7: Column bits above the low log2(L) bits equal those of the start column in every beat.
- R8: `cmd_ready` is high only while no burst is in flight. The first pair is offered in the cycle after a command is accepted. While `out_ready` is low and the burst is not stopped, `out_valid` and both addresses hold.
- R9: `done` is high in the cycle the last pair transfers. In the next cycle, `out_valid` is 0 and `cmd_ready` is 1.
- R10: `stop_req` during a read burst raises `done` in that same cycle and ends the burst. A pair handshaken in that cycle still counts.
- R11: `stop_req` during a write burst has no effect. The write burst delivers all its pairs.
- R12: A mode write during a burst does not change the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_word | input | 4 | [2:0] length code, [3] order select |
| mode_illegal | output | 1 | Previous mode write had a reserved length code |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_col | input | 8 | Start column |
| cmd_bank | input | 2 | Bank select |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| stop_req | input | 1 | Burst terminate request |
| out_valid | output | 1 | Address pair offered |
| out_ready | input | 1 | Consumer takes the pair |
| out_col_even | output | 8 | Column for the even beat |
| out_col_odd | output | 8 | Column for the odd beat |
| out_bank | output | 2 | Bank of the burst |
| done | output | 1 | Burst end pulse |

## Verification
The assertions check the following on every cycle:
- the command port stays closed while pairs are offered;
- a stalled pair holds steady;
- `done` only appears with a pair on offer and frees the command port in the next cycle;
- a write burst never ends while stalled;
- the bits above the burst block never differ between the two lanes.

Only the bench scenarios can show the following:
- the exact address order for each length and ordering;
- the pair count;
- the rejection of reserved length codes;
- the insulation of a running burst from mode writes.

These scenarios combine directed wrap cases with random bursts under random back-pressure and stop requests.

// File: rtl/ddr_colseq_pkg.sv
package ddr_colseq_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;

  typedef struct packed {
    logic [1:0] len_log;  // log2 of burst length: 1, 2 or 3
    order_e     order;
  } burst_mode_t;

  localparam int MODE_W = 4;
  localparam int LEN_LOG_W = 2;
endpackage

// File: rtl/colseq_mode_reg.sv
module colseq_mode_reg
  import ddr_colseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  output burst_mode_t       mode_q,
  output logic              illegal_q
);
  logic                 code_ok;
  logic [LEN_LOG_W-1:0] dec_log;

  always_comb begin
    code_ok = 1'b1;
    dec_log = 2'd1;
    case (mode_word[2:0])
      3'd1:    dec_log = 2'd1;
      3'd2:    dec_log = 2'd2;
      3'd3:    dec_log = 2'd3;
      default: code_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '{len_log: 2'd1, order: ORD_SEQ};
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= mode_wr & ~code_ok;
      if (mode_wr && code_ok)
        mode_q <= '{len_log: dec_log, order: order_e'(mode_word[3])};
    end
  end
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen
  import ddr_colseq_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int IDX_W = 3
) (
  input  logic [COL_W-1:0]     start_col,
  input  logic [IDX_W-2:0]     pair_idx,
  input  logic [LEN_LOG_W-1:0] len_log,
  input  order_e               order,
  output logic [COL_W-1:0]     col_even,
  output logic [COL_W-1:0]     col_odd
);
  logic [COL_W-1:0] lane_col [2];

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [IDX_W-1:0] beat;
    logic [COL_W-1:0] mask, low;
    always_comb begin
      beat = {pair_idx, 1'(ln)};
      mask = (COL_W'(1) << len_log) - COL_W'(1);
      low  = (order == ORD_XOR) ? (start_col ^ COL_W'(beat))
                                : (start_col + COL_W'(beat));
      lane_col[ln] = (start_col & ~mask) | (low & mask);
    end
  end

  assign col_even = lane_col[0];
  assign col_odd  = lane_col[1];
endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import ddr_colseq_pkg::*;
#(
  parameter int PIDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_wr,
  input  logic                 stop_req,
  input  logic                 out_ready,
  input  logic [LEN_LOG_W-1:0] len_log,
  output logic                 cmd_ready,
  output logic                 load,
  output logic                 out_valid,
  output logic [PIDX_W-1:0]    pair_idx,
  output logic                 burst_wr,
  output logic                 done
);
  logic              busy_q;
  logic [PIDX_W-1:0] pair_q;
  logic [PIDX_W-1:0] last_idx;
  logic              fire, stop_ok;

  always_comb last_idx = PIDX_W'((32'd1 << (len_log - 2'd1)) - 32'd1);

  assign cmd_ready = ~busy_q;
  assign load      = cmd_valid & ~busy_q;
  assign out_valid = busy_q;
  assign pair_idx  = pair_q;
  assign fire      = busy_q & out_ready;
  assign stop_ok   = busy_q & stop_req & ~burst_wr;
  assign done      = (fire && pair_q == last_idx) | stop_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pair_q   <= '0;
      burst_wr <= 1'b0;
    end else if (load) begin
      busy_q   <= 1'b1;
      pair_q   <= '0;
      burst_wr <= cmd_wr;
    end else if (done) begin
      busy_q   <= 1'b0;
    end else if (fire) begin
      pair_q   <= pair_q + PIDX_W'(1);
    end
  end
endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
  import ddr_colseq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  output logic              mode_illegal,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_write,
  input  logic              stop_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_col_even,
  output logic [COL_W-1:0]  out_col_odd,
  output logic [BANK_W-1:0] out_bank,
  output logic              done
);
  localparam int IDX_W  = $clog2(MAX_BL);
  localparam int PIDX_W = IDX_W - 1;

  burst_mode_t       mode_q, mode_b;
  logic [COL_W-1:0]  col_q;
  logic [BANK_W-1:0] bank_q;
  logic              load, burst_wr;
  logic [PIDX_W-1:0] pair_idx;

  colseq_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word),
    .mode_q(mode_q), .illegal_q(mode_illegal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      bank_q <= '0;
      mode_b <= '{len_log: 2'd1, order: ORD_SEQ};
    end else if (load) begin
      col_q  <= cmd_col;
      bank_q <= cmd_bank;
      mode_b <= mode_q;
    end
  end

  colseq_ctrl #(.PIDX_W(PIDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_write),
    .stop_req(stop_req), .out_ready(out_ready), .len_log(mode_b.len_log),
    .cmd_ready(cmd_ready), .load(load), .out_valid(out_valid),
    .pair_idx(pair_idx), .burst_wr(burst_wr), .done(done)
  );

  colseq_addr_gen #(.COL_W(COL_W), .IDX_W(IDX_W)) u_addr (
    .start_col(col_q), .pair_idx(pair_idx), .len_log(mode_b.len_log),
    .order(mode_b.order), .col_even(out_col_even), .col_odd(out_col_odd)
  );

  assign out_bank = bank_q;
endmodule

// File: rtl/colseq_checker.sv
module colseq_checker #(
  parameter int COL_W = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [COL_W-1:0] out_col_even,
  input logic [COL_W-1:0] out_col_odd,
  input logic             burst_wr,
  input logic             done
);
  a_r8_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

  a_r8_first_pair_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> out_valid);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !done) |=>
      (out_valid && $stable(out_col_even) && $stable(out_col_odd)));

  a_r9_done_frees_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cmd_ready && !out_valid));

  a_r9_done_with_pair: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  a_r11_write_not_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && burst_wr && !out_ready) |-> !done);

  a_r7_upper_bits_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_col_even[COL_W-1:IDX_W] == out_col_odd[COL_W-1:IDX_W]));
endmodule

bind ddr_burst_colseq colseq_checker #(.COL_W(COL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_col_even(out_col_even),
  .out_col_odd(out_col_odd), .burst_wr(burst_wr), .done(done)
);

// File: tb/ddr_burst_colseq_test.sv
module ddr_burst_colseq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [3:0] mode_word = 4'd0;
  logic       mode_illegal;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_col = 8'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_write = 1'b0;
  logic       stop_req = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_col_even, out_col_odd;
  logic [1:0] out_bank;
  logic       done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_log = 1;
  bit m_xor = 1'b0;

  always #5 clk = ~clk;

  ddr_burst_colseq uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word),
    .mode_illegal(mode_illegal), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_col(cmd_col), .cmd_bank(cmd_bank), .cmd_write(cmd_write),
    .stop_req(stop_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_col_even(out_col_even), .out_col_odd(out_col_odd),
    .out_bank(out_bank), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] s, int i, int lg, bit x);
    int n, lo, r;
    n = 1 << lg;
    lo = int'(s) % n;
    r = x ? (lo ^ i) : ((lo + i) % n);
    return 8'(int'(s) - lo + r);
  endfunction

  function automatic bit legal_code(logic [3:0] w);
    return (w[2:0] >= 3'd1) && (w[2:0] <= 3'd3);
  endfunction

  task automatic set_mode(logic [3:0] w);
    @(negedge clk);
    mode_wr = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_wr = 1'b0;
    #1;
    chk(mode_illegal == !legal_code(w), "R3", "illegal flag",
        int'(mode_illegal), int'(!legal_code(w)));
    if (legal_code(w)) begin
      m_log = int'(w[2:0]);
      m_xor = w[3];
    end
    @(negedge clk);
    chk(mode_illegal == 1'b0, "R3", "illegal flag one cycle", int'(mode_illegal), 0);
  endtask

  task automatic run_burst(logic [7:0] col, logic [1:0] bank, bit wr,
                           int stop_at, bit mid_en, logic [3:0] mid_w);
    int lg, np, k, xfers, it;
    bit x, ended, rdy, stp, stopped;
    string oreq;
    lg = m_log; x = m_xor; np = (1 << lg) / 2;
    k = 0; xfers = 0; it = 0; ended = 0; stopped = 0;
    oreq = x ? "R5" : "R4";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = col; cmd_bank = bank; cmd_write = wr;
    #1;
    chk(cmd_ready == 1'b1, "R8", "cmd_ready idle", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!ended) begin
      rdy = ($urandom % 3) != 0;
      stp = (k == stop_at);
      out_ready = rdy;
      stop_req = stp;
      if (mid_en && it == 0) begin
        mode_wr = 1'b1;
        mode_word = mid_w;
      end
      #1;
      chk(out_valid == 1'b1, "R8", "out_valid in burst", int'(out_valid), 1);
      chk(cmd_ready == 1'b0, "R8", "cmd_ready busy", int'(cmd_ready), 0);
      chk(out_col_even == exp_col(col, 2 * k, lg, x), oreq, "even column",
          int'(out_col_even), int'(exp_col(col, 2 * k, lg, x)));
      chk(out_col_odd == exp_col(col, 2 * k + 1, lg, x), oreq, "odd column",
          int'(out_col_odd), int'(exp_col(col, 2 * k + 1, lg, x)));
      chk((out_col_odd >> lg) == (col >> lg), "R7", "upper column bits",
          int'(out_col_odd >> lg), int'(col >> lg));
      chk(out_bank == bank, "R6", "bank", int'(out_bank), int'(bank));
      stopped = stp && !wr;
      ended = (rdy && k == np - 1) || stopped;
      chk(done == ended, stopped ? "R10" : (wr && stp ? "R11" : "R9"), "done",
          int'(done), int'(ended));
      if (rdy) begin
        xfers++;
        k++;
      end
      it++;
      @(negedge clk);
      mode_wr = 1'b0;
      out_ready = 1'b0;
      stop_req = 1'b0;
    end
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after end", int'(out_valid), 0);
    chk(cmd_ready == 1'b1, "R9", "cmd_ready after end", int'(cmd_ready), 1);
    if (!stopped)
      chk(xfers == np, wr && stop_at < np ? "R11" : "R6", "pair count", xfers, np);
    if (mid_en && legal_code(mid_w)) begin
      m_log = int'(mid_w[2:0]);
      m_xor = mid_w[3];
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", int'(cmd_ready), 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(mode_illegal == 1'b0, "R1", "reset illegal", int'(mode_illegal), 0);
    // R1 default length 2 sequential, odd start
    run_burst(8'h37, 2'd1, 1'b0, 99, 1'b0, 4'd0);
    // R2 R4 sequential wrap cases
    set_mode(4'b0_010);
    run_burst(8'h12, 2'd2, 1'b0, 99, 1'b0, 4'd0);
    run_burst(8'h13, 2'd3, 1'b1, 99, 1'b0, 4'd0);
    set_mode(4'b0_011);
    run_burst(8'hA5, 2'd0, 1'b0, 99, 1'b0, 4'd0);
    run_burst(8'h07, 2'd1, 1'b1, 99, 1'b0, 4'd0);
    // R5 interleaved
    set_mode(4'b1_011);
    run_burst(8'h5E, 2'd2, 1'b0, 99, 1'b0, 4'd0);
    set_mode(4'b1_010);
    run_burst(8'hC3, 2'd3, 1'b0, 99, 1'b0, 4'd0);
    set_mode(4'b1_001);
    run_burst(8'hFF, 2'd0, 1'b1, 99, 1'b0, 4'd0);
    // R3 reserved codes leave length 2 interleaved in force
    set_mode(4'b0_000);
    set_mode(4'b0_101);
    set_mode(4'b0_111);
    run_burst(8'h42, 2'd1, 1'b0, 99, 1'b0, 4'd0);
    // R10 read stop, R11 write stop ignored
    set_mode(4'b0_011);
    run_burst(8'h21, 2'd2, 1'b0, 2, 1'b0, 4'd0);
    run_burst(8'h21, 2'd2, 1'b0, 0, 1'b0, 4'd0);
    run_burst(8'h34, 2'd3, 1'b1, 1, 1'b0, 4'd0);
    // R12 mode write during a burst
    run_burst(8'h66, 2'd0, 1'b0, 99, 1'b1, 4'b1_001);
    run_burst(8'h66, 2'd0, 1'b0, 99, 1'b0, 4'd0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [3:0] w;
      w = 4'($urandom);
      if ($urandom % 4 == 0) set_mode(w);
      run_burst(8'($urandom), 2'($urandom), 1'($urandom),
                ($urandom % 3 == 0) ? int'($urandom % 4) : 99, 1'b0, 4'd0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule